// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one beat per clock, the column address sequence of a single read or write burst in a synchronous DRAM whose rows hold 256 columns. When a column command is accepted it captures the start column, the ordering bit and the 3-bit length code, then steps through the burst. Each cycle it presents the current column, a flag saying the column is live, and a flag marking the final beat of a finite burst.

The ordering bit chooses between a counting order and a bit-flip order. Both stay inside the aligned block that the burst length defines. A full-row length wraps around the whole row and runs until it is stopped. A stop request ends a burst early. A new command, either a plain start or an interrupt carrying its own column, replaces the running sequence at once and may arrive on any clock. Length codes that have no meaning are refused, so they never start a burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_vld_o` and `beat_last_o` are 0 and `col_o` is 0.
- R2: A command (`start_i` or `intr_i`) with a legal code is accepted at a clock edge. From that edge on, `beat_vld_o` is 1 and `col_o` holds the start column (`intr_col_i` if `intr_i` is high, otherwise `col_i`). `intr_i` wins when both are high.
- R3: Length code 3'b000, 3'b001, 3'b010 and 3'b011 gives 1, 2, 4 and 8 beats on consecutive cycles. `beat_last_o` is 1 on the final beat only, `beat_last_o` implies `beat_vld_o`, and `beat_vld_o` falls on the cycle after the final beat unless a new command is accepted.
- R4: With `ileave_i`=0 (sequential), beat k carries the upper column bits of the start column unchanged. Its low log2(BL) bits equal the start column's low bits plus k, modulo BL.
- R5: With `ileave_i`=1 (interleaved), beat k carries the start column XOR k, where k < BL.
- R6: Code 3'b111 with `ileave_i`=0 is a full-row burst. The column counts up by one each cycle and wraps from 255 to 0. The burst never ends by itself, and `beat_last_o` stays 0.
- R7: Codes 3'b100, 3'b101 and 3'b110 in both orderings, and 3'b111 with `ileave_i`=1, are reserved. A command with a reserved code starts nothing, and a burst already running continues untouched.
- R8: `term_i` high at an edge with no accepted command makes `beat_vld_o` and `beat_last_o` 0 from that edge on.
- R9: An accepted command replaces a running burst at any beat and overrides a `term_i` in the same cycle. Its ordering and length come from `ileave_i` and `len_code_i` of that cycle.
- R10: Commands may be accepted on every clock. Each one is followed directly by its own first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe using `col_i` |
| col_i | input | 8 | Start column for `start_i` |
| ileave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| len_code_i | input | 3 | Burst length code |
| term_i | input | 1 | Stop the running burst |
| intr_i | input | 1 | Interrupting command using `intr_col_i` |
| intr_col_i | input | 8 | Start column for `intr_i` |
| col_o | output | 8 | Current column |
| beat_vld_o | output | 1 | `col_o` is a live beat |
| beat_last_o | output | 1 | Final beat of a finite burst |

## Verification
All three outputs are registered, so each one reacts exactly one clock edge after the inputs that cause it. The first beat of an accepted command, the drop after a stop request and the drop after a final beat are therefore all visible in the cycle following the stimulus edge. The bench drives its inputs on the falling edge and reads the outputs on the next falling edge. Every expected beat is compared at the half-cycle after the edge that should have produced it. The checker properties use `|=>` for the same one-cycle relation.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_ROW   = 3'b111
    } bl_code_e;

    // Legality of a length code under a given ordering.
    function automatic logic code_legal(input logic [2:0] code, input logic ileave);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011: code_legal = 1'b1;
            3'b111:                         code_legal = ~ileave;
            default:                        code_legal = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic [2:0]       code_i,
    input  logic             ileave_i,
    output logic             legal_o,
    output logic             row_o,
    output logic [COL_W-1:0] mask_o
);
    always_comb begin
        legal_o = code_legal(code_i, ileave_i);
        row_o   = 1'b0;
        mask_o  = '0;
        case (code_i)
            BL_TWO:   mask_o = COL_W'(1);
            BL_FOUR:  mask_o = COL_W'(3);
            BL_EIGHT: mask_o = COL_W'(7);
            BL_ROW: begin
                mask_o = '1;
                row_o  = ~ileave_i;
            end
            default:  mask_o = '0;
        endcase
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ileave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;

    always_comb begin
        seq_low = (base_i + beat_i) & mask_i;
        xor_low = (base_i ^ beat_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (ileave_i ? xor_low : seq_low);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             ileave_i,
    input  logic [2:0]       len_code_i,
    input  logic             term_i,
    input  logic             intr_i,
    input  logic [COL_W-1:0] intr_col_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             beat_last_o
);
    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] col;
        logic             ileave;
        logic             row;
        logic             vld;
        logic             last;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic             cmd_legal;
    logic             cmd_row;
    logic [COL_W-1:0] cmd_mask;
    logic [COL_W-1:0] next_beat;
    logic [COL_W-1:0] next_col;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i   (len_code_i),
        .ileave_i (ileave_i),
        .legal_o  (cmd_legal),
        .row_o    (cmd_row),
        .mask_o   (cmd_mask)
    );

    assign next_beat = st_q.beat + COL_W'(1);

    burst_addr_calc #(.COL_W(COL_W)) u_addr (
        .base_i   (st_q.base),
        .beat_i   (next_beat),
        .mask_i   (st_q.mask),
        .ileave_i (st_q.ileave),
        .col_o    (next_col)
    );

    always_comb begin
        logic             take;
        logic [COL_W-1:0] start_col;
        st_d      = st_q;
        take      = (start_i | intr_i) & cmd_legal;
        start_col = intr_i ? intr_col_i : col_i;
        if (take) begin
            st_d.base   = start_col;
            st_d.beat   = '0;
            st_d.mask   = cmd_mask;
            st_d.col    = start_col;
            st_d.ileave = ileave_i;
            st_d.row    = cmd_row;
            st_d.vld    = 1'b1;
            st_d.last   = ~cmd_row & (cmd_mask == '0);
        end else if (st_q.vld && !term_i && !st_q.last) begin
            st_d.beat = next_beat;
            st_d.col  = next_col;
            st_d.last = ~st_q.row & (next_beat == st_q.mask);
        end else begin
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o       = st_q.col;
    assign beat_vld_o  = st_q.vld;
    assign beat_last_o = st_q.last;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic             ileave_i,
    input logic [2:0]       len_code_i,
    input logic             term_i,
    input logic             intr_i,
    input logic [COL_W-1:0] intr_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             beat_last_o
);
    logic cmd;
    logic ok;
    logic acc;
    assign cmd = start_i | intr_i;
    assign ok  = code_legal(len_code_i, ileave_i);
    assign acc = cmd & ok;

    assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (beat_vld_o && col_o == $past(intr_i ? intr_col_i : col_i)));

    assert_last_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_vld_o);

    assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && len_code_i == 3'b000) |=> beat_last_o);

    assert_row_nolast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && len_code_i == 3'b111) |=> (beat_vld_o && !beat_last_o));

    assert_row_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !beat_last_o && !term_i) |=> beat_vld_o);

    assert_reserved_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld_o && cmd && !ok) |=> !beat_vld_o);

    assert_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !acc) |=> (!beat_vld_o && !beat_last_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .col_i       (col_i),
    .ileave_i    (ileave_i),
    .len_code_i  (len_code_i),
    .term_i      (term_i),
    .intr_i      (intr_i),
    .intr_col_i  (intr_col_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .beat_last_o (beat_last_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] col_i = '0;
    logic       ileave_i = 1'b0;
    logic [2:0] len_code_i = '0;
    logic       term_i = 1'b0;
    logic       intr_i = 1'b0;
    logic [7:0] intr_col_i = '0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       beat_last_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .ileave_i(ileave_i), .len_code_i(len_code_i), .term_i(term_i),
        .intr_i(intr_i), .intr_col_i(intr_col_i), .col_o(col_o),
        .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o)
    );

    // {ileave, code, start col, beats, beat0..beat7 columns}
    localparam logic [79:0] VEC [8] = '{
        {1'b0, 3'b011, 8'h05, 4'd8, 64'h05060700_01020304},
        {1'b1, 3'b011, 8'h05, 4'd8, 64'h05040706_01000302},
        {1'b0, 3'b010, 8'h1D, 4'd4, 64'h1D1E1F1C_00000000},
        {1'b1, 3'b010, 8'h1D, 4'd4, 64'h1D1C1F1E_00000000},
        {1'b0, 3'b001, 8'h81, 4'd2, 64'h81800000_00000000},
        {1'b1, 3'b001, 8'h80, 4'd2, 64'h80810000_00000000},
        {1'b0, 3'b000, 8'hFF, 4'd1, 64'hFF000000_00000000},
        {1'b1, 3'b011, 8'hF3, 4'd8, 64'hF3F2F1F0_F7F6F5F4}
    };

    task automatic chk(input string req, input logic ev, input logic el,
                       input logic [7:0] ec, input bit care_col);
        total++;
        if (beat_vld_o !== ev || beat_last_o !== el || (care_col && col_o !== ec)) begin
            bad++;
            $display("FAIL %s: got vld=%b last=%b col=%h, want vld=%b last=%b col=%h",
                     req, beat_vld_o, beat_last_o, col_o, ev, el, ec);
        end
    endtask

    // Drive one command cycle; returns at the falling edge where its first beat shows.
    task automatic issue(input logic is_intr, input logic il, input logic [2:0] code,
                         input logic [7:0] c);
        ileave_i = il;
        len_code_i = code;
        if (is_intr) begin intr_i = 1'b1; intr_col_i = c; end
        else begin start_i = 1'b1; col_i = c; end
        @(negedge clk);
        start_i = 1'b0;
        intr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0, 8'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 1'b0, 1'b0, 8'h00, 1'b1);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            logic [79:0] e;
            int n;
            e = VEC[v];
            n = int'(e[67:64]);
            issue(1'b0, e[79], e[78:76], e[75:68]);
            for (int k = 0; k < n; k++) begin
                chk(e[79] ? "R5 R3 interleaved beat" : "R4 R3 sequential beat",
                    1'b1, (k == n - 1), e[63-8*k -: 8], 1'b1);
                @(negedge clk);
            end
            chk("R3 burst end", 1'b0, 1'b0, 8'h00, 1'b0);
        end

        // R7: reserved codes while idle
        issue(1'b0, 1'b0, 3'b100, 8'h10); chk("R7 code 100", 1'b0, 1'b0, 8'h00, 1'b0);
        issue(1'b0, 1'b1, 3'b101, 8'h10); chk("R7 code 101", 1'b0, 1'b0, 8'h00, 1'b0);
        issue(1'b1, 1'b0, 3'b110, 8'h10); chk("R7 code 110", 1'b0, 1'b0, 8'h00, 1'b0);
        issue(1'b0, 1'b1, 3'b111, 8'h10); chk("R7 interleaved 111", 1'b0, 1'b0, 8'h00, 1'b0);

        // R7: reserved command during a burst leaves it running
        issue(1'b0, 1'b0, 3'b011, 8'h40);
        chk("R2 start 40", 1'b1, 1'b0, 8'h40, 1'b1);
        @(negedge clk);
        issue(1'b0, 1'b1, 3'b111, 8'h99);
        chk("R7 burst untouched", 1'b1, 1'b0, 8'h42, 1'b1);
        // R8: terminate mid-burst
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 terminate", 1'b0, 1'b0, 8'h00, 1'b0);

        // R6: full row from FD, wraps through 0, never last
        issue(1'b0, 1'b0, 3'b111, 8'hFD);
        for (int k = 0; k < 300; k++) begin
            chk("R6 full row", 1'b1, 1'b0, 8'(8'hFD + k), 1'b1);
            @(negedge clk);
        end
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 end full row", 1'b0, 1'b0, 8'h00, 1'b0);

        // R9: interrupt replaces a running burst with new column and length
        issue(1'b0, 1'b0, 3'b011, 8'h10);
        chk("R2 start 10", 1'b1, 1'b0, 8'h10, 1'b1);
        @(negedge clk);
        chk("R4 beat 11", 1'b1, 1'b0, 8'h11, 1'b1);
        issue(1'b1, 1'b0, 3'b010, 8'h42);
        chk("R9 interrupt beat0", 1'b1, 1'b0, 8'h42, 1'b1);
        @(negedge clk); chk("R9 interrupt beat1", 1'b1, 1'b0, 8'h43, 1'b1);
        @(negedge clk); chk("R9 interrupt beat2", 1'b1, 1'b0, 8'h40, 1'b1);
        @(negedge clk); chk("R9 interrupt beat3", 1'b1, 1'b1, 8'h41, 1'b1);
        @(negedge clk); chk("R9 interrupt end", 1'b0, 1'b0, 8'h00, 1'b0);

        // R9: command beats terminate; interrupt beats start
        issue(1'b0, 1'b1, 3'b011, 8'h20);
        term_i = 1'b1;
        intr_i = 1'b1; intr_col_i = 8'h66; start_i = 1'b1; col_i = 8'h77;
        ileave_i = 1'b1; len_code_i = 3'b001;
        @(negedge clk);
        term_i = 1'b0; intr_i = 1'b0; start_i = 1'b0;
        chk("R9 intr over term and start", 1'b1, 1'b0, 8'h66, 1'b1);
        @(negedge clk); chk("R9 R5 second beat", 1'b1, 1'b1, 8'h67, 1'b1);
        @(negedge clk); chk("R9 done", 1'b0, 1'b0, 8'h00, 1'b0);

        // R10: back-to-back commands every clock
        ileave_i = 1'b0; len_code_i = 3'b011;
        start_i = 1'b1; col_i = 8'h20;
        @(negedge clk);
        chk("R10 first", 1'b1, 1'b0, 8'h20, 1'b1);
        col_i = 8'h31;
        @(negedge clk);
        chk("R10 second", 1'b1, 1'b0, 8'h31, 1'b1);
        col_i = 8'h47; len_code_i = 3'b000;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 R3 third single", 1'b1, 1'b1, 8'h47, 1'b1);
        @(negedge clk);
        chk("R10 idle", 1'b0, 1'b0, 8'h00, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule